// File: doc/BRIEF.md
# Interrupt-Capable GPIO Port

This block is one 32-pin general-purpose I/O port sitting on a small memory-mapped register bus. Software drives pins through an output-value register and an output-enable register. It reads the pins back through an input register that is fed by a two-flop synchroniser.

Each pin can also raise an interrupt. Four per-pin configuration registers control this:
- a source-route bit lets the pin reach the status register at all;
- a detection-kind bit picks level or edge detection;
- a sense bit picks high/rising or low/falling;
- an unmask bit lets a pending status bit reach the single port interrupt line.

Detected conditions are latched into a sticky status register. Every configuration register accepts a plain write, a set alias and a clear alias, so single bits can be changed without a read-modify-write. Status bits can only be removed through the clear alias.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register reads zero, `pin_out` and `pin_oe` are zero (all pins are inputs) and `irq` is low.
- R2: The register is selected by `bus_addr[6:4]`: 0 output value, 1 input value, 2 output enable, 3 source route, 4 unmask, 5 detection kind, 6 sense, 7 status. The access kind is selected by `bus_addr[3:2]`: 0 plain write, 1 set alias, 2 clear alias, 3 no effect. A read returns the selected register whatever the access kind is.
- R3: A set-alias write ORs the data into the register and a clear-alias write removes the bits given as 1. Bits given as 0 keep their value.
- R4: `pin_out` equals the output value register and `pin_oe` equals the output enable register; a 1 makes the pin an output.
- R5: The input value register shows `pin_in` through two flops: a change driven before one clock edge reads back after the second edge.
- R6: With detection kind 0, sense 1 selects a rising edge and sense 0 selects a falling edge. The status bit becomes readable after the third clock edge following the pin change, and not after the second.
- R7: With detection kind 1, sense 1 selects a high level and sense 0 selects a low level. While the active level persists, a clear-alias write to status has no lasting effect.
- R8: A pin whose source-route bit is 0 never sets its status bit.
- R9: Status is cleared only through its clear alias; plain and set-alias writes to status, and any write to the input value register, change nothing.
- R10: `irq` is high exactly when some bit is set in both status and unmask; the unmask register does not affect status latching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 7 | Byte address: register index and access kind |
| bus_wdata | input | 32 | Write data / bit mask |
| bus_rdata | output | 32 | Read data of the addressed register |
| pin_in | input | 32 | Pin levels from the pads |
| pin_out | output | 32 | Output value to the pads |
| pin_oe | output | 32 | Per-pin output enable |
| irq | output | 1 | Combined port interrupt |

## Verification
The hardest case to reach is a status bit whose detection condition is still active in the same cycle that software clears it. For level pins the bit must come straight back; for edge pins it must stay gone. The stimulus first holds random pin patterns steady under level detection and writes all ones to the status clear alias. It then checks that exactly the routed pins at their active level remain pending. It repeats the same with edge detection, flipping random pin subsets after a clear. Directed sequences also pin down the exact cycle at which a single edge becomes visible.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [2:0] {
    REG_DOUT  = 3'd0,
    REG_DIN   = 3'd1,
    REG_OE    = 3'd2,
    REG_ROUTE = 3'd3,
    REG_IEN   = 3'd4,
    REG_KIND  = 3'd5,
    REG_SENSE = 3'd6,
    REG_STAT  = 3'd7
  } reg_sel_e;

  typedef enum logic [1:0] {
    ACC_WRITE = 2'd0,
    ACC_SET   = 2'd1,
    ACC_CLR   = 2'd2,
    ACC_NONE  = 2'd3
  } acc_kind_e;

  localparam int REG_COUNT = 8;
  localparam int IDX_LSB   = 4;
  localparam int ACC_LSB   = 2;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
    end
  end

  assign sync_out = sync_q;
endmodule

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r, q_nxt;
  logic         q_en;

  assign q_en = wr_en | set_en | clr_en;

  always_comb begin
    q_nxt = q_r;
    if (wr_en)       q_nxt = wdata;
    else if (set_en) q_nxt = q_r | wdata;
    else if (clr_en) q_nxt = q_r & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_r <= '0;
    else if (q_en) q_r <= q_nxt;
  end

  assign q = q_r;

  // R3: set alias leaves every masked bit at one
  assert_set_alias_R3: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ((q_r & $past(wdata)) == $past(wdata)));

  // R3: clear alias leaves every masked bit at zero
  assert_clr_alias_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((q_r & $past(wdata)) == '0));

  // R3: with no access the register holds
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !q_en |=> $stable(q_r));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_s,
  input  logic [W-1:0] route,
  input  logic [W-1:0] kind,
  input  logic [W-1:0] sense,
  input  logic         clr_en,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] stat
);
  logic [W-1:0] prev_q, cond, hit, stat_q, stat_nxt;
  logic         stat_en;

  for (genvar g = 0; g < W; g++) begin : g_pin
    logic edge_rise, edge_fall, lvl_act;
    assign edge_rise = pin_s[g] & ~prev_q[g];
    assign edge_fall = ~pin_s[g] & prev_q[g];
    assign lvl_act   = sense[g] ? pin_s[g] : ~pin_s[g];
    assign cond[g]   = kind[g] ? lvl_act : (sense[g] ? edge_rise : edge_fall);
  end

  assign hit     = cond & route;
  assign stat_en = clr_en | (|hit);

  always_comb begin
    stat_nxt = stat_q;
    if (clr_en) stat_nxt = stat_nxt & ~clr_mask;
    stat_nxt = stat_nxt | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= pin_s;
      if (stat_en) stat_q <= stat_nxt;
    end
  end

  assign stat = stat_q;

  // R9: pending bits stay unless named in a clear-alias write
  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(stat_q) & ~($past(clr_en) ? $past(clr_mask) : '0) & ~stat_q) == '0));

  // R8: an unrouted pin never turns a status bit on
  assert_route_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(route)) == '0));

  // R7: a cleared bit with no active condition is gone the next cycle
  assert_clear_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((stat_q & $past(clr_mask & ~hit)) == '0));
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_pkg::*;
#(
  parameter int PIN_W  = 32,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PIN_W-1:0]  bus_wdata,
  output logic [PIN_W-1:0]  bus_rdata,
  input  logic [PIN_W-1:0]  pin_in,
  output logic [PIN_W-1:0]  pin_out,
  output logic [PIN_W-1:0]  pin_oe,
  output logic              irq
);
  localparam int IDX_W = $clog2(REG_COUNT);

  logic             rst_sync_n;
  logic [IDX_W-1:0] idx;
  logic [1:0]       acc;
  logic [PIN_W-1:0] pin_s, stat;
  logic [PIN_W-1:0] reg_q [REG_COUNT];

  assign idx = bus_addr[IDX_LSB +: IDX_W];
  assign acc = bus_addr[ACC_LSB +: 2];

  gpio_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  gpio_pin_sync #(.W(PIN_W)) u_sync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .async_in (pin_in),
    .sync_out (pin_s)
  );

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
    if (i == int'(REG_DIN)) begin : g_din
      assign reg_q[i] = pin_s;
    end else if (i == int'(REG_STAT)) begin : g_stat
      assign reg_q[i] = stat;
    end else begin : g_cfg
      logic sel;
      assign sel = bus_wr && (idx == IDX_W'(i));
      gpio_alias_reg #(.W(PIN_W)) u_reg (
        .clk    (clk),
        .rst_n  (rst_sync_n),
        .wr_en  (sel && (acc == ACC_WRITE)),
        .set_en (sel && (acc == ACC_SET)),
        .clr_en (sel && (acc == ACC_CLR)),
        .wdata  (bus_wdata),
        .q      (reg_q[i])
      );
    end
  end

  gpio_irq_detect #(.W(PIN_W)) u_det (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .pin_s    (pin_s),
    .route    (reg_q[REG_ROUTE]),
    .kind     (reg_q[REG_KIND]),
    .sense    (reg_q[REG_SENSE]),
    .clr_en   (bus_wr && (idx == IDX_W'(REG_STAT)) && (acc == ACC_CLR)),
    .clr_mask (bus_wdata),
    .stat     (stat)
  );

  assign bus_rdata = reg_q[idx];
  assign pin_out   = reg_q[REG_DOUT];
  assign pin_oe    = reg_q[REG_OE];
  assign irq       = |(stat & reg_q[REG_IEN]);

  // R10: no pending status means no interrupt
  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (stat == '0) |-> !irq);

  // R10: an interrupt implies some unmasked bit
  assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq |-> (reg_q[REG_IEN] != '0));

  // R4: pads follow their registers
  assert_pad_drive_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pin_oe == reg_q[REG_OE]) && (pin_out == reg_q[REG_DOUT]));
endmodule

// File: tb/sim_gpio_irq_port.sv
module sim_gpio_irq_port;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_wr = 1'b0;
  logic [6:0]   bus_addr = '0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic [W-1:0] pin_in = '0;
  logic [W-1:0] pin_out, pin_oe;
  logic         irq;

  int n_tests = 0;
  int n_fail  = 0;
  logic [W-1:0] mdl [8];

  always #5 clk = ~clk;

  gpio_irq_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  function automatic logic [W-1:0] apply_acc(logic [W-1:0] old, int acc, logic [W-1:0] d);
    case (acc)
      0: return d;
      1: return old | d;
      2: return old & ~d;
      default: return old;
    endcase
  endfunction

  function automatic logic [W-1:0] level_exp(logic [W-1:0] route, logic [W-1:0] sense,
                                             logic [W-1:0] p);
    return route & ((sense & p) | (~sense & ~p));
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(int idx, int acc, logic [W-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 7'((idx << 4) | (acc << 2)); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    if (idx != 1 && idx != 7) mdl[idx] = apply_acc(mdl[idx], acc, d);
  endtask

  task automatic rd_now(int idx, output logic [W-1:0] d);
    bus_addr = 7'(idx << 4);
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_neg(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] r, p, x, sense, route, ien;
    void'($urandom(32'd2024));
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    wait_neg(3);
    rst_n = 1'b1;
    wait_neg(4);

    // R1 reset state
    for (int i = 0; i < 8; i++) begin
      rd_now(i, r);
      check("R1 reset reg", r, '0);
    end
    check("R1 pin_oe", pin_oe, '0);
    check("R1 irq", W'(irq), '0);

    // R2/R3/R4 random register accesses checked against the model
    for (int it = 0; it < 300; it++) begin
      int sel_tab [6] = '{0, 2, 3, 4, 5, 6};
      int idx = sel_tab[$urandom_range(0, 5)];
      int acc = $urandom_range(0, 3);
      bus_write(idx, acc, $urandom());
      bus_addr = 7'((idx << 4) | ($urandom_range(0, 3) << 2));
      #1;
      check("R2 R3 readback", bus_rdata, mdl[idx]);
      check("R4 pin_out", pin_out, mdl[0]);
      check("R4 pin_oe", pin_oe, mdl[2]);
    end

    // clean configuration for detection tests
    for (int i = 3; i <= 6; i++) bus_write(i, 0, '0);
    bus_write(7, 2, '1);

    // R5 / R6 rising edge timing on pin 3
    bus_write(5, 0, '0);
    bus_write(6, 0, 32'h8);
    bus_write(3, 0, 32'h8);
    bus_write(7, 2, '1);
    @(negedge clk); pin_in = 32'h8;
    wait_neg(2);
    rd_now(7, r); check("R6 not before third edge", r, '0);
    rd_now(1, r); check("R5 input after two edges", r, 32'h8);
    @(negedge clk);
    rd_now(7, r); check("R6 rising edge latched", r, 32'h8);
    bus_write(7, 2, '1);
    wait_neg(3);
    rd_now(7, r); check("R6 edge cleared stays clear", r, '0);

    // R6 falling edge on pin 3
    bus_write(6, 0, '0);
    @(negedge clk); pin_in = 32'h0;
    wait_neg(3);
    rd_now(7, r); check("R6 falling edge latched", r, 32'h8);

    // R9 plain and set writes to status and writes to input value are ignored
    bus_write(7, 0, '0);
    rd_now(7, r); check("R9 plain write to status", r, 32'h8);
    bus_write(7, 1, 32'hF0);
    rd_now(7, r); check("R9 set write to status", r, 32'h8);
    bus_write(1, 0, '1);
    rd_now(1, r); check("R9 input value unwritable", r, '0);

    // R10 unmask gating
    check("R10 masked no irq", W'(irq), '0);
    bus_write(4, 0, 32'h8);
    #1; check("R10 unmasked irq", W'(irq), 1);
    bus_write(4, 0, '0);
    rd_now(7, r); check("R10 status kept while masked", r, 32'h8);
    bus_write(7, 2, 32'h8);
    rd_now(7, r); check("R9 clear alias clears", r, '0);

    // R7 high level persists through clear
    bus_write(5, 0, 32'h1);
    bus_write(6, 0, 32'h1);
    bus_write(3, 0, 32'h1);
    @(negedge clk); pin_in = 32'h1;
    wait_neg(4);
    bus_write(7, 2, '1);
    rd_now(7, r); check("R7 level reasserts", r, 32'h1);
    @(negedge clk); pin_in = 32'h0;
    wait_neg(4);
    rd_now(7, r); check("R7 low pin still pending", r, 32'h1);
    bus_write(7, 2, '1);
    rd_now(7, r); check("R7 clears once inactive", r, '0);

    // R8 unrouted pin at active level
    bus_write(3, 0, '0);
    bus_write(6, 0, '0);
    wait_neg(3);
    bus_write(7, 2, '1);
    wait_neg(2);
    rd_now(7, r); check("R8 unrouted never pending", r, '0);

    // R7 R8 R10 random level patterns
    bus_write(5, 0, '1);
    for (int it = 0; it < 20; it++) begin
      p = $urandom(); sense = $urandom(); route = $urandom(); ien = $urandom();
      @(negedge clk); pin_in = p;
      bus_write(6, 0, sense);
      bus_write(3, 0, route);
      bus_write(4, 0, ien);
      wait_neg(2);
      bus_write(7, 2, '1);
      rd_now(7, r);
      check("R7 R8 random level", r, level_exp(route, sense, p));
      check("R10 random irq", W'(irq), W'(|(level_exp(route, sense, p) & ien)));
    end

    // R6 random edge patterns
    bus_write(3, 0, '1);
    bus_write(5, 0, '0);
    for (int it = 0; it < 20; it++) begin
      sense = $urandom();
      bus_write(6, 0, sense);
      wait_neg(3);
      bus_write(7, 2, '1);
      rd_now(7, r); check("R6 stable pins no edge", r, '0);
      x = $urandom();
      p = pin_in ^ x;
      @(negedge clk); pin_in = p;
      wait_neg(3);
      rd_now(7, r);
      check("R6 random edges", r, x & ((p & sense) | (~p & ~sense)));
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule